// File: doc/BRIEF.md
# Gated 13-Bit Timer/Counter with Cycle Prescaler

This block is a single timer/counter whose 13-bit count is split across two byte-wide registers. The count has two parts. A 5-bit prescale field sits in the lower register and acts as a divide-by-32 stage. An 8-bit count field sits in the upper register. Counting can follow one of two sources. The first is internal machine cycles, where one machine cycle is a fixed number of clock periods (12 by default). The second is falling edges on an external event pin, which is sampled once per machine cycle. When the count wraps from all ones to zero, a sticky overflow flag is set.

Counting is enabled by a run bit. A gate bit makes counting also depend on a gate pin, so the block counts only while that pin is high. This lets software measure the width of a high pulse. Software loads either register through a plain write strobe, reads both registers at all times, and clears the flag through a clear input.

The block has no streaming data path. Every port is a plain control or status signal and there is no back-pressure. A write strobe is accepted on the clock edge where it is high, with no handshake.

Top module: `tc13_timer`

## Requirements
- R1: After reset the count is zero, the overflow flag is low, and the machine-cycle phase restarts so that the first machine-cycle boundary falls on the 12th rising clock edge.
- R2: In cycle mode (`src_pin`=0) with counting enabled, the 13-bit count advances by exactly one per machine cycle, so any 240 consecutive clocks add exactly 20.
- R3: In pin mode (`src_pin`=1), `evt_pin` is sampled at every machine-cycle boundary. A sample of 1 followed by a sample of 0 at the next boundary records one event. The count advances by one at the boundary after that, so each full high/low period of at least one machine cycle per level adds exactly one.
- R4: In pin mode, an `evt_pin` held steadily low or steadily high adds nothing.
- R5: The count is 13 bits. The prescale field is bits 4..0 of `cnt_lo`. `cnt_lo` bits 7..5 always read 0, and the same bits of a write to the lower register are ignored. A carry out of the prescale field goes straight into `cnt_hi`.
- R6: An increment from 13'h1FFF gives zero and sets `ovf_flag` on that same edge.
- R7: `ovf_flag` stays set until `flag_clr` is sampled high. If a wrap and a clear fall on the same edge, the flag ends up set.
- R8: Counting happens only while `run_en`=1 and either `gate_en`=0 or `gate_pin`=1. Otherwise the count holds.
- R9: A write (`wr_en`=1) loads `wr_data` into the lower register (`wr_hi_sel`=0) or the upper register (`wr_hi_sel`=1) on the next edge. Any increment due on that edge is discarded, and the other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run bit; counting requires 1 |
| gate_en | input | 1 | Gate bit; when 1, counting also requires gate_pin high |
| src_pin | input | 1 | Count source: 0 machine cycles, 1 falling edges of evt_pin |
| evt_pin | input | 1 | External event pin |
| gate_pin | input | 1 | External gate pin used when gate_en is 1 |
| wr_en | input | 1 | Register write strobe |
| wr_hi_sel | input | 1 | Write target: 0 lower register, 1 upper register |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clears the overflow flag |
| cnt_lo | output | 8 | Lower register: prescale field in bits 4..0, zeros above |
| cnt_hi | output | 8 | Upper register: 8-bit count field |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Assertions check the following on every cycle: machine-cycle boundaries are isolated, event records change only at boundaries, the count holds whenever it is disabled and not written, the unused lower-register bits stay zero, a wrap sets the flag, the flag stays set without a clear, and a written field shows the written value on the next clock. Only the bench scenarios can show the rates and latencies: exactly one increment per machine cycle, one per full pin period, nothing for a level held steadily, and the one-boundary delay between event detection and the count change. The bench's cycle-by-cycle model shows these, and directed cases cover the wrap, the set-over-clear collision and a write on a boundary edge.

// File: rtl/tc13_pkg.sv
package tc13_pkg;
  localparam int MC_PHASES = 12;
  localparam int PRE_W     = 5;
  localparam int HI_W      = 8;
  localparam int BYTE_W    = 8;

  typedef enum logic {
    SRC_CYCLES = 1'b0,
    SRC_PIN    = 1'b1
  } src_e;
endpackage

// File: rtl/tc13_mcycle.sv
module tc13_mcycle #(
  parameter int PHASES = tc13_pkg::MC_PHASES
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] ph_q;

  assign tick = (ph_q == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph_q <= '0;
    else if (tick) ph_q <= '0;
    else           ph_q <= ph_q + 1'b1;
  end

  // R2: machine-cycle boundaries never fall on adjacent clocks
  a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tc13_edge.sv
module tc13_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic evt_pend
);
  logic samp_q;
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (tick) begin
      samp_q <= pin;
      pend_q <= samp_q & ~pin;
    end
  end

  assign evt_pend = pend_q;

  // R3: the event record only moves on a machine-cycle boundary
  a_r3_pend_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(evt_pend));
  // R3: a fresh event record needs a low sample of the pin
  a_r3_pend_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pin) |=> !evt_pend);
endmodule

// File: rtl/tc13_count.sv
module tc13_count #(
  parameter int PRE_W  = tc13_pkg::PRE_W,
  parameter int HI_W   = tc13_pkg::HI_W,
  parameter int BYTE_W = tc13_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bump,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_clr,
  output logic [PRE_W+HI_W-1:0] cnt,
  output logic              ovf_flag
);
  localparam int CW = PRE_W + HI_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wr_any;
  logic          wrap;
  logic          flag_q;

  assign wr_any = wr_lo | wr_hi;
  assign wrap   = bump & ~wr_any & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo) cnt_d[PRE_W-1:0]  = wr_data[PRE_W-1:0];
    if (wr_hi) cnt_d[CW-1:PRE_W] = wr_data[HI_W-1:0];
    if (!wr_any && bump) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wrap)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign cnt      = cnt_q;
  assign ovf_flag = flag_q;

  // R6: an increment out of all ones lands on zero with the flag raised
  a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !wr_any && cnt == '1) |=> (ovf_flag && cnt == '0));
  // R7: flag is sticky without a clear
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);
  // R7: wrap beats a simultaneous clear
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && bump && !wr_any && cnt == '1) |=> ovf_flag);
  // R9: a written lower field shows the written value next clock
  a_r9_lo_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt[PRE_W-1:0] == $past(wr_data[PRE_W-1:0]));
  // R9: a written upper field shows the written value next clock
  a_r9_hi_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> cnt[CW-1:PRE_W] == $past(wr_data[HI_W-1:0]));
endmodule

// File: rtl/tc13_timer.sv
module tc13_timer #(
  parameter int PHASES = tc13_pkg::MC_PHASES,
  parameter int PRE_W  = tc13_pkg::PRE_W,
  parameter int HI_W   = tc13_pkg::HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            gate_en,
  input  logic            src_pin,
  input  logic            evt_pin,
  input  logic            gate_pin,
  input  logic            wr_en,
  input  logic            wr_hi_sel,
  input  logic [HI_W-1:0] wr_data,
  input  logic            flag_clr,
  output logic [HI_W-1:0] cnt_lo,
  output logic [HI_W-1:0] cnt_hi,
  output logic            ovf_flag
);
  import tc13_pkg::*;

  localparam int RW = HI_W;
  localparam int CW = PRE_W + HI_W;

  logic          tick;
  logic          evt_pend;
  logic          cnt_ok;
  logic          bump;
  logic [CW-1:0] cnt;
  src_e          src;

  assign src    = src_e'(src_pin);
  assign cnt_ok = run_en & (~gate_en | gate_pin);
  assign bump   = tick & cnt_ok & ((src == SRC_PIN) ? evt_pend : 1'b1);

  tc13_mcycle #(.PHASES(PHASES)) u_mcycle (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  tc13_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pin     (evt_pin),
    .evt_pend(evt_pend)
  );

  tc13_count #(.PRE_W(PRE_W), .HI_W(HI_W), .BYTE_W(RW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .bump    (bump),
    .wr_lo   (wr_en & ~wr_hi_sel),
    .wr_hi   (wr_en & wr_hi_sel),
    .wr_data (wr_data),
    .flag_clr(flag_clr),
    .cnt     (cnt),
    .ovf_flag(ovf_flag)
  );

  assign cnt_lo = {{(RW-PRE_W){1'b0}}, cnt[PRE_W-1:0]};
  assign cnt_hi = cnt[CW-1:PRE_W];

  // R5: unused lower-register bits always read zero
  a_r5_lo_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_lo >> PRE_W) == '0);
  // R8: a disabled, unwritten count holds
  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ok && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
  // R2: between boundaries and without writes the count holds
  a_r2_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

// File: tb/tc13_timer_bench.sv
module tc13_timer_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0, gate_en = 1'b0, src_pin = 1'b0;
  logic       evt_pin = 1'b0, gate_pin = 1'b0;
  logic       wr_en = 1'b0, wr_hi_sel = 1'b0, flag_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] cnt_lo, cnt_hi;
  logic       ovf_flag;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  int m_ph, m_cnt;
  bit m_samp, m_pend, m_flag;

  always #(CLK_P/2) clk = ~clk;

  tc13_timer u_tc13_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .gate_en(gate_en),
    .src_pin(src_pin), .evt_pin(evt_pin), .gate_pin(gate_pin),
    .wr_en(wr_en), .wr_hi_sel(wr_hi_sel), .wr_data(wr_data),
    .flag_clr(flag_clr), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .ovf_flag(ovf_flag)
  );

  // behavioural reference, one update per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_samp = 0; m_pend = 0; m_flag = 0;
    end else begin
      bit tk, en, bmp, wrp;
      tk  = (m_ph == 11);
      en  = run_en && (!gate_en || gate_pin);
      bmp = tk && en && (src_pin ? m_pend : 1'b1);
      wrp = 0;
      if (wr_en) begin
        if (wr_hi_sel) m_cnt = (m_cnt % 32) + int'(wr_data) * 32;
        else           m_cnt = (m_cnt / 32) * 32 + int'(wr_data) % 32;
      end else if (bmp) begin
        if (m_cnt == 8191) begin m_cnt = 0; wrp = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (tk) begin
        m_pend = m_samp && !evt_pin;
        m_samp = evt_pin;
      end
      if (wrp) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_ph = (m_ph + 1) % 12;
    end
  end

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int cnt_now();
    return int'(cnt_hi) * 32 + int'(cnt_lo);
  endfunction

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_chk++;
      if (cnt_now() != m_cnt || ovf_flag !== m_flag || cnt_lo[7:5] != 3'b0) begin
        n_fail++;
        $display("FAIL %s model: got cnt %0d flag %0b expected cnt %0d flag %0b",
                 cur_req, cnt_now(), ovf_flag, m_cnt, m_flag);
      end
    end
  endtask

  task automatic wr(bit hi, logic [7:0] d);
    wr_en = 1; wr_hi_sel = hi; wr_data = d;
    step(1);
    wr_en = 0; wr_hi_sel = 0;
  endtask

  task automatic to_boundary();
    while (m_ph != 11) step(1);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    chk("R1 lo", cnt_lo, 0); chk("R1 hi", cnt_hi, 0); chk("R1 flag", ovf_flag, 0);
    step(11); chk("R1 phase", cnt_now(), 0);
    run_en = 1; step(1); chk("R1 first boundary", cnt_now(), 1);
    run_en = 0; step(1);

    cur_req = "R2";
    run_en = 1; c0 = cnt_now(); step(240); chk("R2 rate", cnt_now() - c0, 20);

    cur_req = "R8";
    run_en = 0; c0 = cnt_now(); step(60); chk("R8 run off", cnt_now() - c0, 0);
    run_en = 1; gate_en = 1; gate_pin = 0; c0 = cnt_now();
    step(60); chk("R8 gate low", cnt_now() - c0, 0);
    gate_pin = 1; c0 = cnt_now(); step(60); chk("R8 gate high", cnt_now() - c0, 5);
    gate_en = 0; gate_pin = 0;

    cur_req = "R3";
    src_pin = 1; evt_pin = 1; step(36); c0 = cnt_now();
    for (int k = 0; k < 10; k++) begin
      evt_pin = 0; step(24); evt_pin = 1; step(24);
    end
    step(36); chk("R3 events", cnt_now() - c0, 10);

    cur_req = "R4";
    evt_pin = 0; step(36); c0 = cnt_now();
    step(120); chk("R4 steady low", cnt_now() - c0, 0);
    evt_pin = 1; step(36); c0 = cnt_now();
    step(120); chk("R4 steady high", cnt_now() - c0, 0);

    cur_req = "R3";
    for (int k = 0; k < 40; k++) begin evt_pin = ~evt_pin; step(5); end
    gate_en = 1;
    for (int k = 0; k < 20; k++) begin evt_pin = ~evt_pin; gate_pin = k[1]; step(13); end
    gate_en = 0; gate_pin = 0; evt_pin = 0;

    cur_req = "R5";
    run_en = 0; src_pin = 0; step(2);
    wr(0, 8'hFF); chk("R5 lo pad", cnt_lo, 8'h1F);
    wr(1, 8'h12); wr(0, 8'h1F);
    run_en = 1; step(12); run_en = 0;
    chk("R5 carry lo", cnt_lo, 0); chk("R5 carry hi", cnt_hi, 8'h13);

    cur_req = "R6";
    wr(1, 8'hFF); wr(0, 8'h1F);
    run_en = 1; step(12); run_en = 0;
    chk("R6 wrap cnt", cnt_now(), 0); chk("R6 flag", ovf_flag, 1);
    cur_req = "R7";
    step(24); chk("R7 sticky", ovf_flag, 1);
    flag_clr = 1; step(1); flag_clr = 0; chk("R7 clear", ovf_flag, 0);
    wr(1, 8'hFF); wr(0, 8'h1F);
    run_en = 1; to_boundary(); flag_clr = 1; step(1); flag_clr = 0; run_en = 0;
    chk("R7 set beats clear", ovf_flag, 1); chk("R6 wrap again", cnt_now(), 0);
    flag_clr = 1; step(1); flag_clr = 0;

    cur_req = "R9";
    wr(1, 8'h40); run_en = 1; to_boundary();
    wr(0, 8'h05); chk("R9 lo write wins", cnt_lo, 5); chk("R9 hi kept", cnt_hi, 8'h40);
    to_boundary(); wr(1, 8'h21);
    chk("R9 hi write wins", cnt_hi, 8'h21); chk("R9 lo kept", cnt_lo, 5);
    step(24); run_en = 0; step(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule